// File: doc/BRIEF.md
# Wide-Write Narrow-Read FIFO

This block is a single-clock FIFO whose write port accepts words a whole multiple wider than the words it returns. Every wide word written is stored intact. On the read side it comes back as a run of narrow slices, least-significant slice first. A producer that packs several narrow items into one wide beat can therefore feed a consumer that takes one item at a time.

The storage is an ordinary circular buffer of wide words. The head word is visible at the read port without a read strobe. A slice counter on the read side picks which part of the head word drives `dout`. Each accepted read moves the counter forward by one. The read that takes the last slice also frees the head word and sets the counter back to zero.

A wide word is freed only when a read is asserted while the counter sits on the last slice. The consumer may hold `rd_en` high or pulse it one cycle at a time with gaps of any length, and the slices still arrive in order with none skipped.

Top module: `wide_to_narrow_fifo`

## Requirements
- R1: After reset, `empty` is 1, `valid` is 0 and `full` is 0.
- R2: Slice k of a stored word occupies bits [k*RD_W +: RD_W], where k runs from 0 to RATIO-1. While a word is at the head, `dout` shows slice 0 first. Each accepted read (`rd_en` high while `empty` is 0) advances `dout` to the next higher slice on the following cycle.
- R3: While `rd_en` is low, `dout`, the slice position and the stored words do not change, apart from a write landing in free space.
- R4: The head word is removed only by an accepted read taken while slice RATIO-1 is shown. The same read returns the slice position to 0, so the next word starts at its slice 0.
- R5: A read while `empty` is 1 is ignored and leaves the slice position unchanged.
- R6: `full` is 1 exactly when DEPTH words are stored. A write while `full` is 1 is dropped.
- R7: `valid` is 1 exactly when `empty` is 0.
- R8: Single-cycle read pulses separated by idle cycles deliver every slice of every word in order.
- R9: A write and an accepted read in the same cycle are both carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| din | input | RD_W*RATIO | Wide write data |
| full | output | 1 | Storage holds DEPTH words |
| rd_en | input | 1 | Read strobe, one slice per accepted read |
| dout | output | RD_W | Current slice of the head word |
| empty | output | 1 | No word stored |
| valid | output | 1 | `dout` holds real data |

## Verification
The main target is reads issued as isolated pulses with idle gaps between them. A design that let the slice count alone trigger the pop would lose whole words between pulses, and the slice sequence would jump to a later word. Holding `rd_en` low partway through a word exposes any design that advances or drains on its own. Reads against an empty buffer, followed by a write, catch a counter that moves while nothing is stored. Filling past DEPTH, then draining and checking that exactly DEPTH words come back, catches an overwrite of the head word. A same-cycle write and read checks that neither side is lost.

// File: rtl/wide_to_narrow_fifo.sv
module wide_to_narrow_fifo #(
  parameter int RD_W  = 8,
  parameter int RATIO = 4,
  parameter int DEPTH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [RD_W*RATIO-1:0] din,
  output logic                  full,
  input  logic                  rd_en,
  output logic [RD_W-1:0]       dout,
  output logic                  empty,
  output logic                  valid
);
  localparam int WR_W = RD_W * RATIO;
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SW   = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam int CW   = AW + 1;
  localparam logic [SW-1:0] LAST     = SW'(RATIO - 1);
  localparam logic [AW-1:0] PTR_MAX  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WR_W-1:0] mem [DEPTH];
  logic [AW-1:0]   wptr, rptr;
  logic [CW-1:0]   count;
  logic [SW-1:0]   slice_cnt;
  logic            wr_ok, rd_ok, pop;

  assign empty = (count == '0);
  assign full  = (count == FULL_CNT);
  assign valid = ~empty;
  assign wr_ok = wr_en & ~full;
  assign rd_ok = rd_en & ~empty;
  assign pop   = rd_ok & (slice_cnt == LAST);
  assign dout  = mem[rptr][int'(slice_cnt)*RD_W +: RD_W];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      count     <= '0;
      slice_cnt <= '0;
    end else begin
      if (wr_ok) wptr <= (wptr == PTR_MAX) ? '0 : wptr + 1'b1;
      if (pop)   rptr <= (rptr == PTR_MAX) ? '0 : rptr + 1'b1;
      if (rd_ok) slice_cnt <= pop ? '0 : slice_cnt + 1'b1;
      case ({wr_ok, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/wide_to_narrow_fifo_chk.sv
module wide_to_narrow_fifo_chk #(
  parameter int RD_W  = 8,
  parameter int RATIO = 4,
  parameter int DEPTH = 8
) (
  input logic                                     clk,
  input logic                                     rst_n,
  input logic                                     wr_en,
  input logic                                     rd_en,
  input logic                                     full,
  input logic                                     empty,
  input logic [RD_W-1:0]                          dout,
  input logic [((RATIO > 1) ? $clog2(RATIO) : 1)-1:0] slice_cnt,
  input logic [((DEPTH > 1) ? $clog2(DEPTH) : 1):0]   count
);
  localparam int SW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [SW-1:0] LAST = SW'(RATIO - 1);

  assert_slice_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !empty && slice_cnt != LAST |=> slice_cnt == $past(slice_cnt) + 1'b1);

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en && !empty |=> $stable(dout) && $stable(slice_cnt));

  assert_wrap_on_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !empty && slice_cnt == LAST |=> slice_cnt == '0);

  assert_no_idle_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en && !wr_en |=> $stable(count));

  assert_empty_read_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> $stable(slice_cnt));

  assert_full_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    full && !rd_en |=> full);
endmodule

bind wide_to_narrow_fifo wide_to_narrow_fifo_chk #(
  .RD_W(RD_W), .RATIO(RATIO), .DEPTH(DEPTH)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .full(full),
  .empty(empty), .dout(dout), .slice_cnt(slice_cnt), .count(count)
);

// File: tb/wide_to_narrow_fifo_tb.sv
module wide_to_narrow_fifo_tb_top;
  localparam int RD_W  = 8;
  localparam int RATIO = 4;
  localparam int DEPTH = 8;
  localparam int WR_W  = RD_W * RATIO;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            wr_en = 0;
  logic [WR_W-1:0] din = '0;
  logic            rd_en = 0;
  logic            full, empty, valid;
  logic [RD_W-1:0] dout;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  wide_to_narrow_fifo #(.RD_W(RD_W), .RATIO(RATIO), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .din(din), .full(full),
    .rd_en(rd_en), .dout(dout), .empty(empty), .valid(valid));

  function automatic logic [WR_W-1:0] mkw(input int i);
    return 32'h0101_0101 * (i + 1) + 32'h3020_1000;
  endfunction

  function automatic logic [RD_W-1:0] sl(input logic [WR_W-1:0] w, input int k);
    return w[k*RD_W +: RD_W];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [WR_W-1:0] w);
    @(negedge clk); wr_en = 1; din = w;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse_read();
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drain_word(input logic [WR_W-1:0] w, input string req);
    for (int k = 0; k < RATIO; k++) begin
      chk(req, dout, sl(w, k));
      chk("R7", valid, 1);
      pulse_read();
    end
  endtask

  task automatic t_reset();
    chk("R1 empty", empty, 1);
    chk("R1 valid", valid, 0);
    chk("R1 full", full, 0);
  endtask

  task automatic t_order();
    logic [WR_W-1:0] w = 32'h4433_2211;
    push(w);
    chk("R7 valid", valid, 1);
    drain_word(w, "R2 slice order");
    chk("R4 empty after last slice", empty, 1);
    chk("R7 valid low", valid, 0);
  endtask

  task automatic t_hold();
    logic [WR_W-1:0] w = 32'hD4C3_B2A1;
    push(w);
    pulse_read();
    idle(5);
    chk("R3 dout held", dout, 8'hB2);
    chk("R3 not drained", empty, 0);
    for (int k = 1; k < RATIO; k++) begin
      chk("R3 resume", dout, sl(w, k));
      pulse_read();
      idle(2);
    end
    chk("R3 empty at end", empty, 1);
  endtask

  task automatic t_sparse();
    logic [WR_W-1:0] a = mkw(20);
    logic [WR_W-1:0] b = mkw(40);
    push(a);
    push(b);
    for (int k = 0; k < RATIO; k++) begin
      chk("R8 sparse slice a", dout, sl(a, k));
      pulse_read();
      idle(3);
    end
    chk("R4 next word slice 0", dout, sl(b, 0));
    for (int k = 0; k < RATIO; k++) begin
      chk("R8 sparse slice b", dout, sl(b, k));
      pulse_read();
      idle(1);
    end
    chk("R8 empty", empty, 1);
  endtask

  task automatic t_empty_read();
    logic [WR_W-1:0] w = 32'h8877_6655;
    pulse_read();
    pulse_read();
    pulse_read();
    chk("R5 still empty", empty, 1);
    push(w);
    chk("R5 starts at slice 0", dout, sl(w, 0));
    drain_word(w, "R5 drain");
    chk("R5 empty", empty, 1);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) begin
      chk("R6 not full yet", full, 0);
      push(mkw(i));
    end
    chk("R6 full", full, 1);
    push(32'hFFFF_FFFF);
    chk("R6 still full", full, 1);
    for (int i = 0; i < DEPTH; i++) drain_word(mkw(i), "R6 content");
    chk("R6 dropped write absent", empty, 1);
    chk("R6 full clear", full, 0);
  endtask

  task automatic t_simul();
    logic [WR_W-1:0] x = 32'h1357_9BDF;
    logic [WR_W-1:0] y = 32'h2468_ACE0;
    push(x);
    @(negedge clk); wr_en = 1; din = y; rd_en = 1;
    @(negedge clk); wr_en = 0; rd_en = 0;
    chk("R9 read taken", dout, sl(x, 1));
    for (int k = 1; k < RATIO; k++) begin
      chk("R9 x", dout, sl(x, k));
      pulse_read();
    end
    chk("R9 write kept", empty, 0);
    drain_word(y, "R9 y");
    chk("R9 empty", empty, 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_hold();
    t_sparse();
    t_empty_read();
    t_full();
    t_simul();
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule